// File: doc/BRIEF.md
# Passive Panel Scan Timing Generator

This block derives the scan timing for a passive matrix LCD or EL panel from a single oscillator clock. A programmable divider produces a pixel enable. Position counters built on that enable mark the end of every line and the first line of every frame. The horizontal total is programmed in groups of eight pixel periods. The vertical total is programmed in lines. The frame rate is therefore the pixel rate divided by the product of the two totals.

Two slower outputs ride on the same counters. One is an alternation signal for the panel drive polarity. It flips once per frame, or after a programmed number of line pulses. The other is a wrap-around frame counter that can raise a one-cycle restart pulse for the frame-rate-modulation pattern. All configuration is taken while reset is held and again at each frame boundary. A change to a total or to the divider therefore never cuts a frame short.

Top module: `panel_scan_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, modOut, lineStrobe and frmRestart are 0 and firstLine is 1. pixEn is 0 when the sampled divider field is nonzero.
- R2: A divider field value d (0 to 31) makes pixEn high for one oscillator cycle in every d+1 cycles, so the pixel rate is the oscillator rate divided by 1 to 32.
- R3: A line lasts (cfgHTotal+1)*8 pixel enables. lineStrobe is high only on the pixEn cycle that ends each line.
- R4: A frame lasts cfgVTotal+1 lines. firstLine is high for every cycle of the first line of each frame and low otherwise.
- R5: All configuration inputs are sampled only while reset is held and on the cycle that ends a frame. A change in mid-frame has no effect on any output until the next frame starts.
- R6: With the sampled rate field at 0, modOut toggles exactly on the cycle after each frame end.
- R7: With the rate field n in 1..63, modOut toggles after every n+1 lineStrobe pulses. Its line counter clears at each toggle, and modOut changes at no other time.
- R8: With the repeat bit set, frmRestart is high for the one frame-end cycle on which the frame counter (2^FRAME_W frames, starting at 0 after reset) wraps.
- R9: With the repeat bit clear, frmRestart stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Synchronous active-low reset; configuration is sampled while it is low |
| cfgDiv | input | 5 | Pixel divider field; ratio is value+1 |
| cfgHTotal | input | 7 | Horizontal total in groups of 8 pixels, minus one |
| cfgVTotal | input | 10 | Vertical total in lines, minus one |
| cfgModRate | input | 6 | Alternation rate; 0 means once per frame, else every value+1 lines |
| cfgRepeat | input | 1 | Enables the modulation-pattern restart pulse |
| pixEn | output | 1 | Pixel clock enable |
| lineStrobe | output | 1 | End-of-line pulse, one pixel enable wide |
| firstLine | output | 1 | High during the first line of each frame |
| modOut | output | 1 | Drive alternation signal |
| frmRestart | output | 1 | One-cycle modulation restart pulse |

## Verification
Every output is a function of registers only. After an edge it settles with no further delay. pixEn, lineStrobe, firstLine and frmRestart describe the current cycle, and modOut changes one cycle after the line or frame end that triggers it. A new configuration takes effect from the edge that closes the current frame. The bench changes inputs 2 ns after a rising edge. At each falling edge it compares all five outputs against a reference model that has advanced once per rising edge. Mid-frame configuration changes show that no output moves before that frame edge.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Strobes passed from the scan control to the alternation/frame datapath
  typedef struct packed {
    logic pix;
    logic lineEnd;
    logic frameEnd;
  } scanStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int HT_W  = 7,
  parameter int VT_W  = 10,
  parameter int GROUP = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [HT_W-1:0]  cfgHTotal,
  input  logic [VT_W-1:0]  cfgVTotal,
  output scanStrobe_t      strb,
  output logic             firstLine
);
  localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam logic [GW-1:0] GLAST = GW'(GROUP - 1);

  logic [DIV_W-1:0] divS, divCnt;
  logic [HT_W-1:0]  htS, hCnt;
  logic [VT_W-1:0]  vtS, vCnt;
  logic [GW-1:0]    pixCnt;
  logic pixTick, groupEnd, lineEnd, frameEnd;

  assign pixTick  = (divCnt == divS);
  assign groupEnd = pixTick && (pixCnt == GLAST);
  assign lineEnd  = groupEnd && (hCnt == htS);
  assign frameEnd = lineEnd && (vCnt == vtS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divS   <= cfgDiv;
      htS    <= cfgHTotal;
      vtS    <= cfgVTotal;
      divCnt <= '0;
      pixCnt <= '0;
      hCnt   <= '0;
      vCnt   <= '0;
    end else begin
      divCnt <= pixTick ? '0 : divCnt + 1'b1;
      if (pixTick)  pixCnt <= groupEnd ? '0 : pixCnt + 1'b1;
      if (groupEnd) hCnt   <= lineEnd  ? '0 : hCnt + 1'b1;
      if (lineEnd)  vCnt   <= frameEnd ? '0 : vCnt + 1'b1;
      if (frameEnd) begin
        divS <= cfgDiv;
        htS  <= cfgHTotal;
        vtS  <= cfgVTotal;
      end
    end
  end

  assign strb.pix      = pixTick;
  assign strb.lineEnd  = lineEnd;
  assign strb.frameEnd = frameEnd;
  assign firstLine     = (vCnt == '0);

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable({divS, htS, vtS}));

  // R2
  pix_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pixTick && divS != '0 && !frameEnd) |=> !pixTick);
endmodule

// File: rtl/scan_modfrm.sv
module scan_modfrm
  import scan_pkg::*;
#(
  parameter int MOD_W   = 6,
  parameter int FRAME_W = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  scanStrobe_t      strb,
  input  logic [MOD_W-1:0] cfgModRate,
  input  logic             cfgRepeat,
  output logic             modOut,
  output logic             frmRestart
);
  localparam logic [FRAME_W-1:0] FLAST = '1;

  logic [MOD_W-1:0]   rateS, modCnt;
  logic [FRAME_W-1:0] frameCnt;
  logic               rptS, modToggle, perFrame;

  assign perFrame   = (rateS == '0);
  assign modToggle  = perFrame ? strb.frameEnd : (strb.lineEnd && modCnt >= rateS);
  assign frmRestart = strb.frameEnd && rptS && (frameCnt == FLAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateS    <= cfgModRate;
      rptS     <= cfgRepeat;
      modCnt   <= '0;
      frameCnt <= '0;
      modOut   <= 1'b0;
    end else begin
      if (modToggle) modOut <= ~modOut;
      if (perFrame || modToggle) modCnt <= '0;
      else if (strb.lineEnd)     modCnt <= modCnt + 1'b1;
      if (strb.frameEnd) begin
        frameCnt <= frameCnt + 1'b1;
        rateS    <= cfgModRate;
        rptS     <= cfgRepeat;
      end
    end
  end

  // R7
  mod_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lineEnd |=> $stable(modOut));

  // R6
  mod_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (perFrame && !strb.frameEnd) |=> $stable(modOut));

  // R8
  restart_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmRestart |=> (frameCnt == '0));
endmodule

// File: rtl/panel_scan_timer.sv
module panel_scan_timer
  import scan_pkg::*;
#(
  parameter int DIV_W   = 5,
  parameter int HT_W    = 7,
  parameter int VT_W    = 10,
  parameter int MOD_W   = 6,
  parameter int FRAME_W = 18,
  parameter int GROUP   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [HT_W-1:0]  cfgHTotal,
  input  logic [VT_W-1:0]  cfgVTotal,
  input  logic [MOD_W-1:0] cfgModRate,
  input  logic             cfgRepeat,
  output logic             pixEn,
  output logic             lineStrobe,
  output logic             firstLine,
  output logic             modOut,
  output logic             frmRestart
);
  scanStrobe_t strb;

  scan_ctrl #(.DIV_W(DIV_W), .HT_W(HT_W), .VT_W(VT_W), .GROUP(GROUP)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgDiv(cfgDiv), .cfgHTotal(cfgHTotal),
    .cfgVTotal(cfgVTotal), .strb(strb), .firstLine(firstLine)
  );

  scan_modfrm #(.MOD_W(MOD_W), .FRAME_W(FRAME_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgModRate(cfgModRate),
    .cfgRepeat(cfgRepeat), .modOut(modOut), .frmRestart(frmRestart)
  );

  assign pixEn      = strb.pix;
  assign lineStrobe = strb.lineEnd;
endmodule

// File: tb/sim_panel_scan_timer.sv
module sim_panel_scan_timer;
  localparam int FW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic [4:0] cfgDiv = 5'd1;
  logic [6:0] cfgHTotal = 7'd0;
  logic [9:0] cfgVTotal = 10'd2;
  logic [5:0] cfgModRate = 6'd0;
  logic       cfgRepeat = 1'b1;
  logic pixEn, lineStrobe, firstLine, modOut, frmRestart;

  panel_scan_timer #(.FRAME_W(FW)) u0 (
    .clk(clk), .rstN(rstN), .cfgDiv(cfgDiv), .cfgHTotal(cfgHTotal),
    .cfgVTotal(cfgVTotal), .cfgModRate(cfgModRate), .cfgRepeat(cfgRepeat),
    .pixEn(pixEn), .lineStrobe(lineStrobe), .firstLine(firstLine),
    .modOut(modOut), .frmRestart(frmRestart)
  );

  int tests = 0, fails = 0, restartCnt = 0;
  bit valid = 0, pending = 0;
  int mDiv, mPos, mLine, mMc, mFrame, sDiv, sHt, sVt, sRate;
  bit mMod, sRpt;

  function automatic void chk(string req, logic got, logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endfunction

  function automatic void chkInt(string req, int got, int exp, bit atLeast);
    tests++;
    if (atLeast ? (got < exp) : (got != exp)) begin
      fails++;
      $display("FAIL %s: got %0d expected %s%0d", req, got, atLeast ? ">=" : "", exp);
    end
  endfunction

  // Reference model: compare at falling edge, then advance to the state after the next rising edge
  always @(negedge clk) begin
    bit pe, le, fe;
    pe = (mDiv == sDiv);
    le = pe && (mPos == (sHt + 1) * 8 - 1);
    fe = le && (mLine == sVt);
    if (valid) begin
      chk("R2 pixEn", pixEn, pe);
      chk(pending ? "R5 lineStrobe" : "R3 lineStrobe", lineStrobe, le);
      chk("R4 firstLine", firstLine, mLine == 0);
      chk(sRate == 0 ? "R6 modOut" : "R7 modOut", modOut, mMod);
      chk(sRpt ? "R8 frmRestart" : "R9 frmRestart", frmRestart,
          fe && (mFrame == (1 << FW) - 1) && sRpt);
      if (frmRestart === 1'b1) restartCnt++;
    end
    if (!rstN) begin
      mDiv = 0; mPos = 0; mLine = 0; mMc = 0; mFrame = 0; mMod = 0;
      sDiv = cfgDiv; sHt = cfgHTotal; sVt = cfgVTotal; sRate = cfgModRate; sRpt = cfgRepeat;
      valid = 1; pending = 0;
    end else if (valid) begin
      if (sRate == 0) begin
        if (fe) mMod = ~mMod;
        mMc = 0;
      end else if (le) begin
        if (mMc >= sRate) begin mMod = ~mMod; mMc = 0; end
        else mMc++;
      end
      if (pe) begin
        mDiv = 0;
        if (le) begin
          mPos = 0;
          mLine = fe ? 0 : mLine + 1;
        end else mPos++;
      end else mDiv++;
      if (fe) begin
        mFrame = (mFrame + 1) % (1 << FW);
        sDiv = cfgDiv; sHt = cfgHTotal; sVt = cfgVTotal; sRate = cfgModRate; sRpt = cfgRepeat;
        if (pending) begin pending = 0; restartCnt = 0; end
      end
    end
  end

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic setCfg(int d, int h, int v, int r, bit rp);
    cfgDiv = 5'(d); cfgHTotal = 7'(h); cfgVTotal = 10'(v);
    cfgModRate = 6'(r); cfgRepeat = rp; pending = 1;
  endtask

  task automatic resetChecks();
    @(negedge clk);
    chk("R1 modOut", modOut, 1'b0);
    chk("R1 lineStrobe", lineStrobe, 1'b0);
    chk("R1 frmRestart", frmRestart, 1'b0);
    chk("R1 firstLine", firstLine, 1'b1);
    chk("R1 pixEn", pixEn, 1'b0);
  endtask

  initial begin
    waitCycles(3);
    resetChecks();
    @(posedge clk); #2;
    rstN = 1'b1;
    restartCnt = 0;
    waitCycles(900);                       // 18+ frames of 48 cycles
    chkInt("R8 restart seen", restartCnt, 1, 1'b1);
    waitCycles(5);
    setCfg(2, 1, 1, 2, 1'b0);              // mid-frame change
    waitCycles(2000);
    chkInt("R9 no restart", restartCnt, 0, 1'b0);
    setCfg(31, 3, 0, 5, 1'b1);
    waitCycles(6000);
    setCfg(0, 127, 3, 1, 1'b1);
    waitCycles(9000);
    setCfg(3, 2, 1, 0, 1'b0);
    waitCycles(300);
    rstN = 1'b0;
    waitCycles(2);
    resetChecks();
    @(posedge clk); #2;
    rstN = 1'b1;
    waitCycles(400);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule